// File: doc/BRIEF.md
# Configurable LUT-Pair Logic Cluster

This block is one tile of a fine-grained reconfigurable fabric that sits beside a processor's execute stage and computes custom operations. It holds eight logic cells. Each cell has two 4-input lookup tables that always see the same four input signals, so one cell can produce a sum bit and a carry bit together, or two different functions of one input group. Each cell also has one user flip-flop that captures the first table's output. A single configuration bit per cell selects whether the cell's primary output is the table value or the value held in that flop.

The cluster takes one byte from each of two processor operands and 24 signals from neighbouring clusters. It drives one result byte and 24 signals towards its neighbours. All routing is a sparse crossbar built from small fixed-size multiplexers. Every table input picks one of seven fixed candidates, and every output bit picks one of four fixed candidates. The candidates come from a pool of 56 signals: the operand bits, the primary and secondary outputs of all cells, and the neighbour inputs. All table contents and multiplexer selects arrive as one flat configuration vector. The datapath is combinational from operands to result, except where a cell is switched to its flop.

Top module: `lut_cluster`

## Requirements
- R1: Configuration layout. Cell c owns bits [45c+44 : 45c]. Within that field, bits [15:0] are the first table, [31:16] the second table, and [34:32], [37:35], [40:38], [43:41] the selects of table inputs i0..i3. Bit 44 is the register select. Result bit r uses select bits [361+2r : 360+2r]. Neighbour output n uses select bits [377+2n : 376+2n]. The vector is 424 bits wide.
- R2: Both tables of a cell are addressed by the same index {i3,i2,i1,i0}, and each outputs its truth-table bit at that index. The second table's output is the cell's secondary output.
- R3: For cell c, select 0 connects i0 to operand A bit c, i1 to operand B bit c, i2 to the secondary output of cell (c+7) mod 8, and i3 to the cell's own primary output. Selects 1 to 6 connect further fixed candidates from the pool.
- R4: A table-input select of 7 drives that input to logic 0.
- R5: Result bit r selects 0: primary output of cell r; 1: secondary output of cell r; 2: secondary output of cell (r+7) mod 8; 3: operand A bit r.
- R6: Neighbour output n = 8g+j (group g, position j) with select 3 passes neighbour input n. In group 0, select 2 gives operand A bit j. In group 1, select 2 gives operand B bit j. In group 2, select 2 gives operand B bit (j+6) mod 8.
- R7: With the register select at 0, a cell's primary output is the first table's output in the same cycle. With it at 1, the primary output is the value the flop captured at the last clock edge.
- R8: Each user flop clears to 0 on a clock edge while rst_n is low. Otherwise it loads the first table's output on every rising edge.
- R9: Paths from operands to the result have no latency when no flop is selected. A ripple-carry 4-bit adder built from four cells gives a correct 5-bit sum for every pair of operand nibbles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the user flip-flops |
| rst_n | input | 1 | Synchronous active-low clear of the user flip-flops |
| cfg_i | input | 424 | Flat configuration: truth tables, multiplexer selects, register selects |
| opa_i | input | 8 | Operand A byte |
| opb_i | input | 8 | Operand B byte |
| nbr_i | input | 24 | Signals arriving from neighbouring clusters |
| res_o | output | 8 | Result byte |
| nbr_o | output | 24 | Signals sent to neighbouring clusters |

## Verification
The hardest state to reach from the ports is a multi-cell chain in which one cell's secondary output feeds the next cell's table input, for example a carry or a running parity. It needs table contents and select codes that agree across several cells at once, and only one or two end bits of the chain are visible on the result byte. The bench composes whole configurations arithmetically: a 4-bit ripple adder and an 8-cell parity chain. It then sweeps every operand nibble pair and hundreds of byte pairs through them. The flop path is reached by building a toggle accumulator whose table input i3 reads the cell's own registered output. That accumulator is checked cycle by cycle against a running XOR.

// File: rtl/lut_cluster_pkg.sv
package lut_cluster_pkg;

  localparam int LC_CELLS     = 8;
  localparam int LC_K         = 4;
  localparam int LC_TT_W      = 1 << LC_K;
  localparam int LC_LUT_CAND  = 7;
  localparam int LC_LUT_SEL_W = $clog2(LC_LUT_CAND + 1);
  localparam int LC_OUT_CAND  = 4;
  localparam int LC_OUT_SEL_W = $clog2(LC_OUT_CAND);
  localparam int LC_NBR       = 24;
  localparam int LC_N_OUT     = LC_CELLS + LC_NBR;

  // pool layout
  localparam int POOL_A   = 0;
  localparam int POOL_B   = LC_CELLS;
  localparam int POOL_PRI = 2 * LC_CELLS;
  localparam int POOL_SEC = 3 * LC_CELLS;
  localparam int POOL_NBR = 4 * LC_CELLS;
  localparam int POOL_W   = 4 * LC_CELLS + LC_NBR;

  // per-cell configuration field
  localparam int CFG_TT0    = 0;
  localparam int CFG_TT1    = LC_TT_W;
  localparam int CFG_SEL    = 2 * LC_TT_W;
  localparam int CFG_REG    = CFG_SEL + LC_K * LC_LUT_SEL_W;
  localparam int CELL_CFG_W = CFG_REG + 1;

  // whole-cluster configuration vector
  localparam int RES_BASE = LC_CELLS * CELL_CFG_W;
  localparam int NBR_BASE = RES_BASE + LC_CELLS * LC_OUT_SEL_W;
  localparam int CFG_W    = NBR_BASE + LC_NBR * LC_OUT_SEL_W;

  function automatic int cwrap(int c);
    return ((c % LC_CELLS) + LC_CELLS) % LC_CELLS;
  endfunction

  function automatic int nwrap(int n);
    return ((n % LC_NBR) + LC_NBR) % LC_NBR;
  endfunction

  // Pool index feeding candidate k of table input p in cell c.
  function automatic int lut_src(int c, int p, int k);
    int s;
    s = POOL_A;
    case (p)
      0: case (k)
           0: s = POOL_A + cwrap(c);
           1: s = POOL_B + cwrap(c);
           2: s = POOL_A + cwrap(c + 1);
           3: s = POOL_B + cwrap(c + 1);
           4: s = POOL_NBR + nwrap(c);
           5: s = POOL_NBR + nwrap(c + LC_CELLS);
           default: s = POOL_NBR + nwrap(c + 2 * LC_CELLS);
         endcase
      1: case (k)
           0: s = POOL_B + cwrap(c);
           1: s = POOL_A + cwrap(c);
           2: s = POOL_A + cwrap(c + 7);
           3: s = POOL_B + cwrap(c + 7);
           4: s = POOL_NBR + nwrap(c + 1 + LC_CELLS);
           5: s = POOL_NBR + nwrap(c + 1 + 2 * LC_CELLS);
           default: s = POOL_SEC + cwrap(c + 4);
         endcase
      2: case (k)
           0: s = POOL_SEC + cwrap(c + 7);
           1: s = POOL_PRI + cwrap(c + 7);
           2: s = POOL_PRI + cwrap(c);
           3: s = POOL_SEC + cwrap(c + 1);
           4: s = POOL_A + cwrap(c + 2);
           5: s = POOL_B + cwrap(c + 2);
           default: s = POOL_NBR + nwrap(c + 3);
         endcase
      default: case (k)
           0: s = POOL_PRI + cwrap(c);
           1: s = POOL_PRI + cwrap(c + 1);
           2: s = POOL_SEC + cwrap(c + 2);
           3: s = POOL_PRI + cwrap(c + 6);
           4: s = POOL_NBR + nwrap(c + 5 + LC_CELLS);
           5: s = POOL_B + cwrap(c + 3);
           default: s = POOL_A + cwrap(c + 5);
         endcase
    endcase
    return s;
  endfunction

  // Pool index feeding candidate k of output bit o
  // (o below LC_CELLS: result bit; otherwise neighbour output o-LC_CELLS).
  function automatic int out_src(int o, int k);
    int s, n, g, j;
    s = POOL_A;
    if (o < LC_CELLS) begin
      case (k)
        0: s = POOL_PRI + o;
        1: s = POOL_SEC + o;
        2: s = POOL_SEC + cwrap(o + 7);
        default: s = POOL_A + o;
      endcase
    end else begin
      n = o - LC_CELLS;
      g = (n / LC_CELLS) % 3;
      j = n % LC_CELLS;
      if (k == 3) s = POOL_NBR + n;
      else case (g)
        0: case (k)
             0: s = POOL_PRI + j;
             1: s = POOL_SEC + j;
             default: s = POOL_A + j;
           endcase
        1: case (k)
             0: s = POOL_PRI + cwrap(j + 3);
             1: s = POOL_SEC + cwrap(j + 5);
             default: s = POOL_B + j;
           endcase
        default: case (k)
             0: s = POOL_SEC + j;
             1: s = POOL_PRI + cwrap(j + 1);
             default: s = POOL_B + cwrap(j + 6);
           endcase
      endcase
    end
    return s;
  endfunction

  function automatic logic lut_read(logic [LC_TT_W-1:0] tt, logic [LC_K-1:0] idx);
    return tt[idx];
  endfunction

endpackage

// File: rtl/lc_mux.sv
module lc_mux #(
  parameter int N  = 7,
  parameter int SW = 3
) (
  input  logic [N-1:0]  d_i,
  input  logic [SW-1:0] sel_i,
  output logic          q_o
);
  // select codes at or above N leave the output at 0
  always_comb begin
    q_o = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (sel_i == SW'(k)) q_o = d_i[k];
    end
  end
endmodule

// File: rtl/lc_lut.sv
module lc_lut
  import lut_cluster_pkg::*;
(
  input  logic [LC_TT_W-1:0] tt_i,
  input  logic [LC_K-1:0]    idx_i,
  output logic               q_o
);
  assign q_o = lut_read(tt_i, idx_i);
endmodule

// File: rtl/lc_cell.sv
module lc_cell
  import lut_cluster_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [CELL_CFG_W-1:0]         cfg_i,
  input  logic [LC_K*LC_LUT_CAND-1:0]   cand_i,
  output logic                          pri_o,
  output logic                          sec_o
);
  logic [LC_TT_W-1:0] tt0, tt1;
  logic               reg_sel;
  logic [LC_K-1:0]    lin;
  logic               lut0, lut1, ff_q;
  logic               all_sel_null;

  assign tt0     = cfg_i[CFG_TT0 +: LC_TT_W];
  assign tt1     = cfg_i[CFG_TT1 +: LC_TT_W];
  assign reg_sel = cfg_i[CFG_REG];

  for (genvar p = 0; p < LC_K; p++) begin : g_in
    lc_mux #(.N(LC_LUT_CAND), .SW(LC_LUT_SEL_W)) u_mux (
      .d_i  (cand_i[p*LC_LUT_CAND +: LC_LUT_CAND]),
      .sel_i(cfg_i[CFG_SEL + p*LC_LUT_SEL_W +: LC_LUT_SEL_W]),
      .q_o  (lin[p])
    );
  end

  lc_lut u_lut0 (.tt_i(tt0), .idx_i(lin), .q_o(lut0));
  lc_lut u_lut1 (.tt_i(tt1), .idx_i(lin), .q_o(lut1));

  always_ff @(posedge clk) begin
    if (!rst_n) ff_q <= 1'b0;
    else        ff_q <= lut0;
  end

  assign pri_o = reg_sel ? ff_q : lut0;
  assign sec_o = lut1;

  // named event: every table input parked on the null select
  always_comb begin
    all_sel_null = 1'b1;
    for (int p = 0; p < LC_K; p++) begin
      if (cfg_i[CFG_SEL + p*LC_LUT_SEL_W +: LC_LUT_SEL_W] != LC_LUT_SEL_W'(LC_LUT_CAND))
        all_sel_null = 1'b0;
    end
  end

  // R2
  shared_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tt0 == tt1) |-> (lut0 == lut1));

  // R4
  null_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    all_sel_null |-> (lut0 == tt0[0] && lut1 == tt1[0]));

  // R8
  ff_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel && !$past(rst_n)) |-> (pri_o == 1'b0));

  // R7
  reg_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel && $past(reg_sel) && $past(rst_n)) |-> (pri_o == $past(lut0)));

endmodule

// File: rtl/lut_cluster.sv
module lut_cluster
  import lut_cluster_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CFG_W-1:0]     cfg_i,
  input  logic [LC_CELLS-1:0]  opa_i,
  input  logic [LC_CELLS-1:0]  opb_i,
  input  logic [LC_NBR-1:0]    nbr_i,
  output logic [LC_CELLS-1:0]  res_o,
  output logic [LC_NBR-1:0]    nbr_o
);
  logic [POOL_W-1:0]   pool;
  logic [LC_CELLS-1:0] pri, sec;
  logic [LC_N_OUT-1:0] out_bits;

  assign pool = {nbr_i, sec, pri, opb_i, opa_i};

  for (genvar c = 0; c < LC_CELLS; c++) begin : g_cell
    logic [LC_K*LC_LUT_CAND-1:0] cand;
    for (genvar p = 0; p < LC_K; p++) begin : g_pos
      for (genvar k = 0; k < LC_LUT_CAND; k++) begin : g_cand
        localparam int SRC = lut_src(c, p, k);
        assign cand[p*LC_LUT_CAND + k] = pool[SRC];
      end
    end
    lc_cell u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .cfg_i (cfg_i[c*CELL_CFG_W +: CELL_CFG_W]),
      .cand_i(cand),
      .pri_o (pri[c]),
      .sec_o (sec[c])
    );
  end

  for (genvar o = 0; o < LC_N_OUT; o++) begin : g_out
    localparam int SEL_LO = (o < LC_CELLS) ? RES_BASE + o*LC_OUT_SEL_W
                                           : NBR_BASE + (o - LC_CELLS)*LC_OUT_SEL_W;
    logic [LC_OUT_CAND-1:0] cand;
    for (genvar k = 0; k < LC_OUT_CAND; k++) begin : g_cand
      localparam int SRC = out_src(o, k);
      assign cand[k] = pool[SRC];
    end
    lc_mux #(.N(LC_OUT_CAND), .SW(LC_OUT_SEL_W)) u_mux (
      .d_i  (cand),
      .sel_i(cfg_i[SEL_LO +: LC_OUT_SEL_W]),
      .q_o  (out_bits[o])
    );
  end

  assign res_o = out_bits[LC_CELLS-1:0];
  assign nbr_o = out_bits[LC_N_OUT-1:LC_CELLS];

  for (genvar r = 0; r < LC_CELLS; r++) begin : g_res_chk
    // R5
    res_opa_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_i[RES_BASE + r*LC_OUT_SEL_W +: LC_OUT_SEL_W] == LC_OUT_SEL_W'(3))
        |-> (res_o[r] == opa_i[r]));
  end

  for (genvar n = 0; n < LC_NBR; n++) begin : g_nbr_chk
    // R6
    nbr_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_i[NBR_BASE + n*LC_OUT_SEL_W +: LC_OUT_SEL_W] == LC_OUT_SEL_W'(3))
        |-> (nbr_o[n] == nbr_i[n]));
  end

endmodule

// File: tb/lut_cluster_tb.sv
module lut_cluster_tb;
  localparam int CW = 45;
  localparam int RB = 360;
  localparam int NB = 376;
  localparam int CFGW = 424;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [CFGW-1:0] cfg = '0;
  logic [7:0]      opa = '0, opb = '0;
  logic [23:0]     nbri = '0;
  wire  [7:0]      res;
  wire  [23:0]     nbro;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  lut_cluster u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_i(cfg), .opa_i(opa), .opb_i(opb),
    .nbr_i(nbri), .res_o(res), .nbr_o(nbro)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // truth tables by function kind: 0 par3, 1 maj3, 2 i0, 3 i0^i3, 4 const1, 5 only addr0
  function automatic logic [15:0] tt_of(int kind);
    logic [15:0] t;
    for (int a = 0; a < 16; a++) begin
      logic i0, i1, i2, i3;
      i0 = a[0]; i1 = a[1]; i2 = a[2]; i3 = a[3];
      case (kind)
        0: t[a] = i0 ^ i1 ^ i2;
        1: t[a] = (i0 & i1) | (i0 & i2) | (i1 & i2);
        2: t[a] = i0;
        3: t[a] = i0 ^ i3;
        4: t[a] = 1'b1;
        default: t[a] = (a == 0);
      endcase
    end
    return t;
  endfunction

  function automatic logic [CFGW-1:0] w_cell(logic [CFGW-1:0] v, int c,
      logic [15:0] t0, logic [15:0] t1, int s0, int s1, int s2, int s3, bit rs);
    v[c*CW +: 16]      = t0;
    v[c*CW + 16 +: 16] = t1;
    v[c*CW + 32 +: 3]  = 3'(s0);
    v[c*CW + 35 +: 3]  = 3'(s1);
    v[c*CW + 38 +: 3]  = 3'(s2);
    v[c*CW + 41 +: 3]  = 3'(s3);
    v[c*CW + 44]       = rs;
    return v;
  endfunction

  function automatic logic [CFGW-1:0] w_res(logic [CFGW-1:0] v, int r, int s);
    v[RB + 2*r +: 2] = 2'(s);
    return v;
  endfunction

  function automatic logic [CFGW-1:0] w_nbr(logic [CFGW-1:0] v, int n, int s);
    v[NB + 2*n +: 2] = 2'(s);
    return v;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [CFGW-1:0] v;
    logic acc;

    // ---- R8: clear during reset, load after release (R1 layout) ----
    v = '0;
    v = w_cell(v, 0, tt_of(4), 16'h0, 7, 7, 7, 7, 1'b1);
    for (int r = 1; r < 8; r++) v = w_res(v, r, 3);
    cfg = v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8 reset clear", 32'(res), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 load after release", 32'(res), 32'h1);

    // ---- R8 / R3: toggle accumulator, i3 = own registered output ----
    v = '0;
    v = w_cell(v, 0, tt_of(3), 16'h0, 0, 7, 7, 0, 1'b1);
    for (int r = 1; r < 8; r++) v = w_res(v, r, 3);
    cfg = v;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    acc = 1'b0;
    for (int i = 0; i < 40; i++) begin
      opa = {7'b0, 1'(((i * 7 + 3) % 5) < 2)};
      @(posedge clk);
      acc = acc ^ opa[0];
      @(negedge clk);
      chk("R8 R3 accumulate", 32'(res[0]), 32'(acc));
    end

    // ---- R7: registered versus combinational primary output ----
    v = '0;
    v = w_cell(v, 0, tt_of(2), 16'h0, 0, 7, 7, 7, 1'b1);
    for (int r = 1; r < 8; r++) v = w_res(v, r, 3);
    cfg = v; opa = 8'h00;
    repeat (2) @(negedge clk);
    opa = 8'h01; #1;
    chk("R7 registered holds old", 32'(res[0]), 32'h0);
    @(negedge clk);
    chk("R7 registered updates", 32'(res[0]), 32'h1);
    v = w_cell(v, 0, tt_of(2), 16'h0, 0, 7, 7, 7, 1'b0);
    cfg = v; opa = 8'h00; #1;
    chk("R7 combinational low", 32'(res), 32'h0);
    opa = 8'h01; #1;
    chk("R7 combinational high", 32'(res), 32'h1);

    // ---- R4 / R2: null select and shared table index ----
    @(negedge clk);
    v = '0;
    v = w_cell(v, 0, tt_of(2), tt_of(2), 7, 7, 7, 7, 1'b0);
    v = w_res(v, 1, 2);
    for (int r = 2; r < 8; r++) v = w_res(v, r, 3);
    cfg = v; opa = 8'hFF; #1;
    chk("R4 null select reads 0", 32'(res[1:0]), 32'h0);
    v = w_cell(v, 0, tt_of(5), tt_of(5), 7, 7, 7, 7, 1'b0);
    cfg = v; #1;
    chk("R4 null select index 0", 32'(res[1:0]), 32'h3);
    v = w_cell(v, 0, tt_of(2), tt_of(2), 0, 7, 7, 7, 1'b0);
    cfg = v; opa = 8'hFE; #1;
    chk("R2 shared index low", 32'(res[1:0]), 32'h0);
    opa = 8'hFF; #1;
    chk("R2 shared index high", 32'(res[1:0]), 32'h3);

    // ---- R9 / R3 / R5: 4-bit ripple adder, exhaustive over nibbles ----
    @(negedge clk);
    v = '0;
    for (int c = 0; c < 4; c++)
      v = w_cell(v, c, tt_of(0), tt_of(1), 0, 0, (c == 0) ? 7 : 0, 7, 1'b0);
    for (int r = 0; r < 4; r++) v = w_res(v, r, 0);
    v = w_res(v, 4, 2);
    for (int r = 5; r < 8; r++) v = w_res(v, r, 3);
    cfg = v;
    for (int x = 0; x < 256; x++) begin
      logic [4:0] sum;
      @(negedge clk);
      opa = {4'(x >> 4) ^ 4'h5, 4'(x)};
      opb = {4'(x), 4'(x >> 4)};
      #1;
      sum = 5'(opa[3:0]) + 5'(opb[3:0]);
      chk("R9 R3 R5 adder", 32'(res), 32'({opa[7:5], sum}));
    end

    // ---- R3 / R5 / R2: eight-cell parity chain ----
    v = '0;
    for (int c = 0; c < 8; c++)
      v = w_cell(v, c, 16'h0, tt_of(0), 0, 0, (c == 0) ? 7 : 0, 7, 1'b0);
    v = w_res(v, 0, 2);
    v = w_res(v, 1, 1);
    for (int r = 2; r < 8; r++) v = w_res(v, r, 3);
    @(negedge clk);
    cfg = v;
    for (int x = 0; x < 512; x++) begin
      logic [7:0] e;
      @(negedge clk);
      opa = 8'(x);
      opb = 8'(x * 29 + 11);
      #1;
      e = opa;
      e[0] = ^(opa ^ opb);
      e[1] = ^(opa[1:0] ^ opb[1:0]);
      chk("R3 R5 parity chain", 32'(res), 32'(e));
    end

    // ---- R6: neighbour output selection ----
    v = '0;
    for (int r = 0; r < 8; r++) v = w_res(v, r, 3);
    for (int n = 0; n < 8; n++) v = w_nbr(v, n, 3);
    for (int n = 8; n < 16; n++) v = w_nbr(v, n, 2);
    for (int n = 16; n < 24; n++) v = w_nbr(v, n, 3);
    @(negedge clk);
    cfg = v;
    for (int x = 0; x < 64; x++) begin
      @(negedge clk);
      nbri = 24'(x * 40503 + 7);
      opa = 8'(x * 13 + 1);
      opb = 8'(x * 91 + 5);
      #1;
      chk("R6 pass and operand B", 32'(nbro), 32'({nbri[23:16], opb, nbri[7:0]}));
    end
    for (int n = 0; n < 8; n++) v = w_nbr(v, n, 2);
    for (int n = 8; n < 16; n++) v = w_nbr(v, n, 3);
    for (int n = 16; n < 24; n++) v = w_nbr(v, n, 2);
    @(negedge clk);
    cfg = v;
    for (int x = 0; x < 64; x++) begin
      logic [7:0] rot;
      @(negedge clk);
      nbri = 24'(x * 7919 + 3);
      opa = 8'(x * 37 + 2);
      opb = 8'(x * 53 + 9);
      #1;
      for (int j = 0; j < 8; j++) rot[j] = opb[(j + 6) % 8];
      chk("R6 operand A and rotated B", 32'(nbro), 32'({rot, nbri[15:8], opa}));
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule